// File: doc/BRIEF.md
# Solder Reflow Profile Sequencer

This block walks an oven heater through a six-phase solder reflow profile. It compares the measured oven temperature with the user setpoints and counts whole seconds from a once-per-second strobe. From these it decides when each phase ends. In the two ramp phases it asks for full heater drive. In the two hold phases it asks for a programmed duty percentage, which a built-in slow time-proportioning generator turns into an on/off heater line.

The setpoints are checked against fixed bounds when a run is started, and a run with bad setpoints never begins. During the first phase a rise watchdog stops the run if the oven has not warmed by a minimum margin within a fixed number of seconds. A stop pulse returns the block to idle with the heater off from any phase. The temperature and the setpoints are plain level inputs that are sampled on every clock. No stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `rf_sequencer`

## Requirements
- R1: After reset, state_o is 0 (Idle), and heat_o, duty_o, full_drive_o, done_o, err_o and err_code_o are all 0.
- R2: In Idle, a start pulse with setpoints inside their bounds moves state_o to 1 (Preheat) on the next clock and clears err_o and err_code_o. Preheat gives full_drive_o=1, duty_o=100 and heat_o=1.
- R3: In Idle, a start pulse with any setpoint outside its bounds leaves state_o at 0 and sets err_o=1 with err_code_o=1. The bounds are soak temperature 130..180, soak time 30..120 s, reflow temperature 200..245 and reflow time 20..90 s.
- R4: Preheat moves to state 2 (Soak) once temp_i is equal to or greater than soak_temp_i. It stays in Preheat while temp_i is below soak_temp_i.
- R5: In Soak, full_drive_o=0 and duty_o=SOAK_DUTY (default 20). heat_o is high for exactly duty_o slots in every 100 consecutive slots.
- R6: Soak moves to state 3 (Ramp) on the clock after the soak_time_i-th tick counted since Soak was entered. Ramp gives full_drive_o=1, duty_o=100 and heat_o=1.
- R7: Ramp moves to state 4 (Reflow) once temp_i is equal to or greater than reflow_temp_i. Reflow gives full_drive_o=0 and duty_o=REFL_DUTY (default 40).
- R8: Reflow moves to state 5 (Cooldown) on the clock after the reflow_time_i-th tick counted since Reflow was entered. In Cooldown, heat_o=0 and duty_o=0.
- R9: Cooldown moves to Idle once temp_i falls below 60. On that clock done_o is high for exactly one cycle.
- R10: In Preheat, once 60 ticks have been counted since entry, if temp_i is below the captured start temperature plus 50, the block goes to Idle with err_o=1 and err_code_o=2. At a rise of 50 or more it stays in Preheat.
- R11: A stop pulse sends any state to Idle on the next clock with heat_o=0 and no done pulse. Stop wins over a start pulse given in the same cycle.
- R12: A start pulse outside Idle has no effect on state_o.
- R13: state_o only ever changes to the next state in the order 0,1,2,3,4,5, or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse, forces Idle |
| temp_i | input | TEMP_W | Oven temperature, unsigned degrees C |
| soak_temp_i | input | TEMP_W | Soak setpoint |
| soak_time_i | input | TIME_W | Soak hold time in seconds |
| reflow_temp_i | input | TEMP_W | Reflow setpoint |
| reflow_time_i | input | TIME_W | Reflow hold time in seconds |
| state_o | output | 3 | Phase code: 0 Idle, 1 Preheat, 2 Soak, 3 Ramp, 4 Reflow, 5 Cooldown |
| full_drive_o | output | 1 | 1 = full drive, 0 = proportional drive |
| duty_o | output | DUTY_W | Requested duty in percent |
| heat_o | output | 1 | Heater on/off command |
| done_o | output | 1 | One-cycle pulse at the end of Cooldown |
| err_o | output | 1 | Error flag |
| err_code_o | output | 2 | 0 none, 1 setpoint bounds, 2 no thermal rise |

## Verification
The bench targets the exact threshold temperatures. A design that uses a strict compare at a setpoint, or a non-strict compare at the cooldown limit, leaves its phase one degree late or early. It counts ticks one short of each hold time, which exposes a seconds counter that is not cleared on entry or that ends a phase early. The watchdog is driven at a rise of 49 and at a rise of 50, which catches a wrong margin or a watchdog that never fires. Random setpoint sets on both sides of every bound check that rejection holds the block in Idle. Stop, start outside Idle, and a stop together with a start expose a design that lets start override the safe path.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PREHEAT = 3'd1,
    ST_SOAK    = 3'd2,
    ST_RAMP    = 3'd3,
    ST_REFLOW  = 3'd4,
    ST_COOL    = 3'd5
  } rf_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_BOUNDS = 2'd1,
    ERR_RISE   = 2'd2
  } rf_err_e;

  localparam int FULL_PCT = 100;
endpackage

// File: rtl/rf_param_check.sv
module rf_param_check #(
  parameter int TEMP_W     = 10,
  parameter int TIME_W     = 9,
  parameter int SOAK_T_MIN = 130,
  parameter int SOAK_T_MAX = 180,
  parameter int SOAK_S_MIN = 30,
  parameter int SOAK_S_MAX = 120,
  parameter int REFL_T_MIN = 200,
  parameter int REFL_T_MAX = 245,
  parameter int REFL_S_MIN = 20,
  parameter int REFL_S_MAX = 90
) (
  input  logic [TEMP_W-1:0] soak_temp_i,
  input  logic [TIME_W-1:0] soak_time_i,
  input  logic [TEMP_W-1:0] reflow_temp_i,
  input  logic [TIME_W-1:0] reflow_time_i,
  output logic              ok_o
);
  logic [3:0] in_range;

  always_comb begin
    in_range[0] = (soak_temp_i   >= TEMP_W'(SOAK_T_MIN)) && (soak_temp_i   <= TEMP_W'(SOAK_T_MAX));
    in_range[1] = (soak_time_i   >= TIME_W'(SOAK_S_MIN)) && (soak_time_i   <= TIME_W'(SOAK_S_MAX));
    in_range[2] = (reflow_temp_i >= TEMP_W'(REFL_T_MIN)) && (reflow_temp_i <= TEMP_W'(REFL_T_MAX));
    in_range[3] = (reflow_time_i >= TIME_W'(REFL_S_MIN)) && (reflow_time_i <= TIME_W'(REFL_S_MAX));
    ok_o = &in_range;
  end
endmodule

// File: rtl/rf_sec_timer.sv
module rf_sec_timer #(
  parameter int TIME_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [TIME_W-1:0] sec_o
);
  localparam logic [TIME_W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sec_o <= '0;
    else if (clr_i)               sec_o <= '0;
    else if (tick_i && sec_o != SAT) sec_o <= sec_o + 1'b1;
  end
endmodule

// File: rtl/rf_tp_pwm.sv
module rf_tp_pwm #(
  parameter int SLOT_CYC = 1000,
  parameter int DUTY_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              full_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              heat_o
);
  localparam int SW = $clog2(SLOT_CYC + 1);
  localparam logic [SW-1:0]     SLOT_LAST  = SW'(SLOT_CYC - 1);
  localparam logic [DUTY_W-1:0] PHASE_LAST = DUTY_W'(rf_pkg::FULL_PCT - 1);

  logic [SW-1:0]     slot_q;
  logic [DUTY_W-1:0] phase_q;
  logic              slot_end;

  assign slot_end = (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else if (clr_i) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else begin
      slot_q <= slot_end ? '0 : slot_q + 1'b1;
      if (slot_end) phase_q <= (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign heat_o = full_i || (phase_q < duty_i);
endmodule

// File: rtl/rf_sequencer.sv
module rf_sequencer
  import rf_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int TIME_W     = 9,
  parameter int DUTY_W     = 7,
  parameter int SOAK_T_MIN = 130,
  parameter int SOAK_T_MAX = 180,
  parameter int SOAK_S_MIN = 30,
  parameter int SOAK_S_MAX = 120,
  parameter int REFL_T_MIN = 200,
  parameter int REFL_T_MAX = 245,
  parameter int REFL_S_MIN = 20,
  parameter int REFL_S_MAX = 90,
  parameter int SOAK_DUTY  = 20,
  parameter int REFL_DUTY  = 40,
  parameter int WDOG_S     = 60,
  parameter int RISE_C     = 50,
  parameter int COOL_C     = 60,
  parameter int SLOT_CYC   = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] soak_temp_i,
  input  logic [TIME_W-1:0] soak_time_i,
  input  logic [TEMP_W-1:0] reflow_temp_i,
  input  logic [TIME_W-1:0] reflow_time_i,
  output logic [2:0]        state_o,
  output logic              full_drive_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              heat_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  localparam logic [TIME_W-1:0] WDOG_LIM = TIME_W'(WDOG_S);
  localparam logic [TEMP_W-1:0] COOL_LIM = TEMP_W'(COOL_C);
  localparam logic [TEMP_W:0]   RISE_ADD = (TEMP_W+1)'(RISE_C);

  rf_state_e         st_q, st_d;
  rf_err_e           code_q, code_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [TEMP_W-1:0] base_q;
  logic              capture;
  logic              entry;
  logic              par_ok;
  logic [TIME_W-1:0] sec;
  logic [TEMP_W:0]   rise_goal;

  rf_param_check #(
    .TEMP_W(TEMP_W), .TIME_W(TIME_W),
    .SOAK_T_MIN(SOAK_T_MIN), .SOAK_T_MAX(SOAK_T_MAX),
    .SOAK_S_MIN(SOAK_S_MIN), .SOAK_S_MAX(SOAK_S_MAX),
    .REFL_T_MIN(REFL_T_MIN), .REFL_T_MAX(REFL_T_MAX),
    .REFL_S_MIN(REFL_S_MIN), .REFL_S_MAX(REFL_S_MAX)
  ) u_check (
    .soak_temp_i  (soak_temp_i),
    .soak_time_i  (soak_time_i),
    .reflow_temp_i(reflow_temp_i),
    .reflow_time_i(reflow_time_i),
    .ok_o         (par_ok)
  );

  rf_sec_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (entry),
    .tick_i(tick_i),
    .sec_o (sec)
  );

  assign rise_goal = {1'b0, base_q} + RISE_ADD;

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    code_d  = code_q;
    capture = 1'b0;
    done_d  = 1'b0;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (par_ok) begin
              st_d    = ST_PREHEAT;
              err_d   = 1'b0;
              code_d  = ERR_NONE;
              capture = 1'b1;
            end else begin
              err_d  = 1'b1;
              code_d = ERR_BOUNDS;
            end
          end
        end
        ST_PREHEAT: begin
          if (temp_i >= soak_temp_i) begin
            st_d = ST_SOAK;
          end else if (sec >= WDOG_LIM && {1'b0, temp_i} < rise_goal) begin
            st_d   = ST_IDLE;
            err_d  = 1'b1;
            code_d = ERR_RISE;
          end
        end
        ST_SOAK:   if (sec >= soak_time_i)      st_d = ST_RAMP;
        ST_RAMP:   if (temp_i >= reflow_temp_i) st_d = ST_REFLOW;
        ST_REFLOW: if (sec >= reflow_time_i)    st_d = ST_COOL;
        ST_COOL: begin
          if (temp_i < COOL_LIM) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign entry = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
      done_q <= 1'b0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      code_q <= code_d;
      done_q <= done_d;
      if (capture) base_q <= temp_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_PREHEAT, ST_RAMP: begin full_drive_o = 1'b1; duty_o = DUTY_W'(FULL_PCT);  end
      ST_SOAK:             begin full_drive_o = 1'b0; duty_o = DUTY_W'(SOAK_DUTY); end
      ST_REFLOW:           begin full_drive_o = 1'b0; duty_o = DUTY_W'(REFL_DUTY); end
      default:             begin full_drive_o = 1'b0; duty_o = '0;                 end
    endcase
  end

  rf_tp_pwm #(.SLOT_CYC(SLOT_CYC), .DUTY_W(DUTY_W)) u_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (entry),
    .full_i(full_drive_o),
    .duty_i(duty_o),
    .heat_o(heat_o)
  );

  assign state_o    = st_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/rf_sequencer_chk.sv
module rf_sequencer_chk #(
  parameter int TEMP_W = 10,
  parameter int TIME_W = 9,
  parameter int DUTY_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              start_i,
  input logic              stop_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic [2:0]        state_o,
  input logic              full_drive_o,
  input logic [DUTY_W-1:0] duty_o,
  input logic              heat_o,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        err_code_o
);
  assert_ramp_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd3) |-> (full_drive_o && heat_o && duty_o == DUTY_W'(100)));

  assert_heat_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 || state_o == 3'd5) |-> (!heat_o && duty_o == '0));

  assert_done_from_cool_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_o == 3'd0 && $past(state_o) == 3'd5));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_stop_safe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_o == 3'd0 && !heat_o && !done_o));

  assert_err_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (state_o == 3'd0 && err_code_o != 2'd0));

  assert_order_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> (state_o == 3'd0 || state_o == $past(state_o) + 3'd1));

  assert_start_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && state_o == 3'd2) |=> (state_o == 3'd2 || state_o == 3'd3));

  logic unused_ok;
  assign unused_ok = ^{tick_i, temp_i};
endmodule

bind rf_sequencer rf_sequencer_chk #(
  .TEMP_W(TEMP_W), .TIME_W(TIME_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
  .stop_i(stop_i), .temp_i(temp_i), .state_o(state_o),
  .full_drive_o(full_drive_o), .duty_o(duty_o), .heat_o(heat_o),
  .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/test_rf_sequencer.sv
module test_rf_sequencer;
  localparam int TW = 10;
  localparam int SW = 9;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic [TW-1:0] temp = '0, s_temp = '0, r_temp = '0;
  logic [SW-1:0] s_time = '0, r_time = '0;
  logic [2:0] state;
  logic full;
  logic [DW-1:0] duty;
  logic heat, done, err;
  logic [1:0] code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rf_sequencer #(.SLOT_CYC(1)) i_rf_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
    .temp_i(temp), .soak_temp_i(s_temp), .soak_time_i(s_time),
    .reflow_temp_i(r_temp), .reflow_time_i(r_time),
    .state_o(state), .full_drive_o(full), .duty_o(duty), .heat_o(heat),
    .done_o(done), .err_o(err), .err_code_o(code)
  );

  function automatic bit bounds_ok(int st, int ss, int rt, int rs);
    return st >= 130 && st <= 180 && ss >= 30 && ss <= 120 &&
           rt >= 200 && rt <= 245 && rs >= 20 && rs <= 90;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic set_temp(int v);
    temp = TW'(v); @(negedge clk);
  endtask

  task automatic load(int st, int ss, int rt, int rs);
    s_temp = TW'(st); s_time = SW'(ss); r_temp = TW'(rt); r_time = SW'(rs);
  endtask

  task automatic run_profile(int st, int ss, int rt, int rs);
    int ones;
    load(st, ss, rt, rs);
    temp = 10'd25;
    pulse_start();
    check("R2 state", state, 1);
    check("R2 err", err, 0);
    check("R2 full", full, 1);
    check("R2 duty", duty, 100);
    check("R2 heat", heat, 1);
    set_temp(st - 1);
    check("R4 below soak", state, 1);
    set_temp(st);
    check("R4 at soak", state, 2);
    check("R5 full", full, 0);
    check("R5 duty", duty, 20);
    ones = 0;
    for (int i = 0; i < 100; i++) begin
      if (heat) ones++;
      @(negedge clk);
    end
    check("R5 on slots", ones, 20);
    pulse_start();
    check("R12 start in soak", state, 2);
    ticks(ss - 1);
    check("R6 one tick short", state, 2);
    ticks(1);
    check("R6 ramp state", state, 3);
    check("R6 ramp full", full, 1);
    check("R13 order", state, 3);
    set_temp(rt - 1);
    check("R7 below reflow", state, 3);
    set_temp(rt);
    check("R7 reflow state", state, 4);
    check("R7 reflow duty", duty, 40);
    check("R7 reflow full", full, 0);
    ticks(rs - 1);
    check("R8 one tick short", state, 4);
    ticks(1);
    check("R8 cool state", state, 5);
    check("R8 cool heat", heat, 0);
    check("R8 cool duty", duty, 0);
    set_temp(60);
    check("R9 at limit", state, 5);
    check("R9 no done", done, 0);
    set_temp(59);
    check("R9 idle", state, 0);
    check("R9 done", done, 1);
    step(1);
    check("R9 done single", done, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd2026);
    step(3);
    check("R1 state", state, 0);
    check("R1 heat", heat, 0);
    check("R1 duty", duty, 0);
    check("R1 full", full, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 code", code, 0);
    rst_n = 1'b1;
    step(2);

    // R3: random setpoint sets across every bound
    for (int i = 0; i < 40; i++) begin
      int st, ss, rt, rs;
      st = 120 + int'($urandom % 70);
      ss = 20 + int'($urandom % 110);
      rt = 190 + int'($urandom % 65);
      rs = 10 + int'($urandom % 90);
      load(st, ss, rt, rs);
      temp = 10'd25;
      pulse_start();
      if (bounds_ok(st, ss, rt, rs)) begin
        check("R2 random accept", state, 1);
        check("R2 random err clear", err, 0);
        pulse_stop();
        check("R11 random stop", state, 0);
      end else begin
        check("R3 random reject state", state, 0);
        check("R3 random reject err", err, 1);
        check("R3 random reject code", code, 1);
      end
    end

    // R3: exact edges
    load(129, 60, 220, 40); pulse_start();
    check("R3 soak temp low", code, 1);
    check("R3 stays idle", state, 0);
    load(130, 30, 245, 90); pulse_start();
    check("R3 edges accepted", state, 1);
    check("R3 err cleared", err, 0);
    pulse_stop();

    // full profiles
    run_profile(150, 40, 220, 25);
    for (int k = 0; k < 2; k++)
      run_profile(130 + int'($urandom % 51), 30 + int'($urandom % 91),
                  200 + int'($urandom % 46), 20 + int'($urandom % 71));

    // R10 watchdog: rise 49 aborts
    load(170, 60, 220, 40);
    temp = 10'd30;
    pulse_start();
    set_temp(79);
    ticks(59);
    check("R10 before limit", state, 1);
    ticks(1);
    check("R10 abort state", state, 0);
    check("R10 abort err", err, 1);
    check("R10 abort code", code, 2);

    // R10 watchdog: rise 50 continues
    temp = 10'd30;
    pulse_start();
    check("R10 restart clears err", err, 0);
    set_temp(80);
    ticks(65);
    check("R10 rise met", state, 1);

    // R11 stop from preheat and stop with start
    pulse_stop();
    check("R11 stop state", state, 0);
    check("R11 stop heat", heat, 0);
    check("R11 stop no done", done, 0);
    start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
    check("R11 stop beats start", state, 0);

    // R11 stop from ramp
    temp = 10'd25;
    load(140, 30, 210, 20);
    pulse_start();
    set_temp(140);
    ticks(30);
    check("R11 in ramp", state, 3);
    pulse_stop();
    check("R11 ramp stop", state, 0);
    check("R11 ramp heat off", heat, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule